// File: doc/BRIEF.md
# Four-Channel Sample Sequencer Controller

This block is the digital half of a converter with four independent sample sequencers. Each sequencer has an enable bit, a 4-bit trigger-source field, a 16-deep result FIFO, sticky overflow and underflow flags, a raw interrupt bit and its own interrupt line. A one-cycle pulse on `timer_trig` makes every enabled sequencer whose source field holds the timer code store one sample and raise its raw interrupt bit.

There is no analog front end. Samples come from a 32-bit linear-congruential noise generator that resets to zero, so the stream of values is fully deterministic. When several sequencers capture on the same pulse, they draw successive values from the generator in ascending sequencer order. Software reaches everything through a simple register port: writes complete in one cycle, and read data appears on `rdata` in the cycle after `rd_en`.

Register map (byte offsets): 0x00 enables [3:0]; 0x04 raw status [3:0] (read); 0x08 interrupt mask [3:0]; 0x0C reads masked status, write 1 to clear raw bits; 0x10 overflow flags (write 1 to clear); 0x14 underflow flags (write 1 to clear); 0x18 source select. Sequencer n occupies 0x40 + 0x20*n, with FIFO data at +0x00 and FIFO status at +0x04.

Top module: `seq_adc_ctrl`

## Requirements
- R1: A trigger pulse leaves sequencer n untouched when bit n of the enable register (0x00) is clear: no sample is stored and the noise generator does not advance.
- R2: Sequencer n captures only when bits [4n+3:4n] of the source register (0x18) equal 5. With any other code, its FIFO stays unchanged.
- R3: Each FIFO holds 16 samples. Reading FIFO data (+0x00) returns the oldest sample and removes it, so reads come back in the order of capture.
- R4: A capture into a full FIFO discards the sample and sets bit n of the overflow register (0x10). The bit stays set until a 1 is written to it.
- R5: Each capture first advances the noise state as state*314159+1 (modulo 2^32, reset value 0), then stores 0x200 + state[18:16]. On a single trigger, lower-numbered sequencers draw first.
- R6: A capture sets raw bit n (0x04). Writing 1 to bit n of 0x0C clears it. `irq[n]` is high exactly when raw bit n and mask bit n (0x08) are both set.
- R7: Reading an empty FIFO sets bit n of the underflow register (0x14) and returns the last sample removed from that FIFO (0 after reset).
- R8: FIFO status (+0x04) shows the read pointer in [3:0], the write pointer in [7:4], empty in bit 8 and full in bit 9.
- R9: After reset, all registers read 0, every FIFO status reads 0x100 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timer_trig | input | 1 | One-cycle timer trigger pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| irq | output | NSEQ | Per-sequencer interrupt lines |

## Verification
The hardest case to reach is a FIFO that is full and keeps receiving triggers, followed by draining it past empty. To get there, the stimulus enables a single sequencer and issues seventeen triggers. This wraps the write pointer back to the read pointer and forces one overflow. The bench then reads all sixteen samples against an independent model of the noise stream and makes one more read, which must return the last sample and set the underflow flag. A separate single trigger with two sequencers enabled checks that the generator hands out consecutive values in index order.

// File: rtl/seq_adc_ctrl.sv
module seq_adc_ctrl #(
  parameter int NSEQ  = 4,
  parameter int DEPTH = 16,
  parameter int AW    = 8,
  parameter int SW    = 10,
  parameter logic [3:0] TIMER_CODE = 4'd5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            timer_trig,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic [NSEQ-1:0] irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [NSEQ-1:0]   en_q, mask_q, raw_q, ovf_q, unf_q;
  logic [4*NSEQ-1:0] src_q;
  logic [31:0]       noise_q, noise_d;
  logic [SW-1:0]     mem [NSEQ][DEPTH];
  logic [PW-1:0]     wp [NSEQ];
  logic [PW-1:0]     rp [NSEQ];
  logic [CW-1:0]     cnt [NSEQ];
  logic [SW-1:0]     last [NSEQ];
  logic [NSEQ-1:0]   cap, pop;
  logic [SW-1:0]     samp [NSEQ];
  logic [31:0]       rd_mux;
  logic              in_seq;
  logic [2:0]        sidx;

  assign irq    = raw_q & mask_q;
  assign in_seq = (addr >= AW'(8'h40)) && (addr < AW'(8'h40 + 32 * NSEQ));
  assign sidx   = 3'(addr[7:5] - 3'd2);

  always_comb begin
    noise_d = noise_q;
    for (int i = 0; i < NSEQ; i++) begin
      cap[i]  = timer_trig && en_q[i] && (src_q[4*i +: 4] == TIMER_CODE);
      samp[i] = '0;
      if (cap[i]) begin
        noise_d = noise_d * 32'd314159 + 32'd1;
        samp[i] = SW'(10'h200) + SW'(noise_d[18:16]);
      end
      pop[i] = rd_en && in_seq && (addr[4:0] == 5'h00) && (sidx == 3'(i));
    end
  end

  always_comb begin
    rd_mux = '0;
    if (in_seq) begin
      for (int i = 0; i < NSEQ; i++) begin
        if (sidx == 3'(i)) begin
          if (addr[4:0] == 5'h00)
            rd_mux = 32'(cnt[i] != 0 ? mem[i][rp[i]] : last[i]);
          else if (addr[4:0] == 5'h04)
            rd_mux = {22'b0, cnt[i] == CW'(DEPTH), cnt[i] == 0, 4'(wp[i]), 4'(rp[i])};
        end
      end
    end else begin
      case (addr)
        AW'(8'h00): rd_mux = 32'(en_q);
        AW'(8'h04): rd_mux = 32'(raw_q);
        AW'(8'h08): rd_mux = 32'(mask_q);
        AW'(8'h0C): rd_mux = 32'(irq);
        AW'(8'h10): rd_mux = 32'(ovf_q);
        AW'(8'h14): rd_mux = 32'(unf_q);
        AW'(8'h18): rd_mux = 32'(src_q);
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0; mask_q <= '0; raw_q <= '0; ovf_q <= '0; unf_q <= '0;
      src_q <= '0; noise_q <= '0; rdata <= '0;
      for (int i = 0; i < NSEQ; i++) begin
        wp[i] <= '0; rp[i] <= '0; cnt[i] <= '0; last[i] <= '0;
      end
    end else begin
      noise_q <= noise_d;
      if (rd_en) rdata <= rd_mux;
      if (wr_en && addr == AW'(8'h00)) en_q   <= wdata[NSEQ-1:0];
      if (wr_en && addr == AW'(8'h08)) mask_q <= wdata[NSEQ-1:0];
      if (wr_en && addr == AW'(8'h18)) src_q  <= wdata[4*NSEQ-1:0];
      for (int i = 0; i < NSEQ; i++) begin
        if (cap[i]) raw_q[i] <= 1'b1;
        else if (wr_en && addr == AW'(8'h0C) && wdata[i]) raw_q[i] <= 1'b0;
        if (cap[i] && cnt[i] == CW'(DEPTH)) ovf_q[i] <= 1'b1;
        else if (wr_en && addr == AW'(8'h10) && wdata[i]) ovf_q[i] <= 1'b0;
        if (pop[i] && cnt[i] == 0) unf_q[i] <= 1'b1;
        else if (wr_en && addr == AW'(8'h14) && wdata[i]) unf_q[i] <= 1'b0;
        if (cap[i] && cnt[i] != CW'(DEPTH)) wp[i] <= wp[i] + 1'b1;
        if (pop[i] && cnt[i] != 0) begin
          rp[i]   <= rp[i] + 1'b1;
          last[i] <= mem[i][rp[i]];
        end
        cnt[i] <= cnt[i] + CW'(cap[i] && cnt[i] != CW'(DEPTH)) - CW'(pop[i] && cnt[i] != 0);
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NSEQ; i++)
      if (rst_n && cap[i] && cnt[i] != CW'(DEPTH)) mem[i][wp[i]] <= samp[i];
  end

  p_noise_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_trig == 1'b0) |=> $stable(noise_q));

  for (genvar g = 0; g < NSEQ; g++) begin : g_chk
    p_off_no_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (timer_trig && !en_q[g] && !pop[g]) |=> (cnt[g] == $past(cnt[g])));
    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[g] <= CW'(DEPTH));
    p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q[g] && !(wr_en && addr == AW'(8'h10) && wdata[g])) |=> ovf_q[g]);
    p_capture_raw_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (timer_trig && en_q[g] && src_q[4*g +: 4] == TIMER_CODE) |=> raw_q[g]);
    p_irq_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == AW'(8'h0C) && wdata[g] && !timer_trig) |=> !irq[g]);
  end
endmodule

// File: tb/sim_seq_adc_ctrl.sv
`timescale 1ns/1ps
module sim_seq_adc_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        timer_trig = 0, wr_en = 0, rd_en = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;
  int checks = 0, failures = 0;
  logic [31:0] mnoise = 0;
  logic [31:0] exp_q [$];
  logic [31:0] lastv, v;
  bit done = 0;

  always #4 clk = ~clk;

  seq_adc_ctrl u0 (.clk, .rst_n, .timer_trig, .wr_en, .rd_en, .addr, .wdata, .rdata, .irq);

  function automatic logic [31:0] next_sample();
    mnoise = mnoise * 32'd314159 + 32'd1;
    return 32'h200 + 32'(mnoise[18:16]);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic trig();
    @(negedge clk); timer_trig = 1;
    @(negedge clk); timer_trig = 0;
  endtask

  task automatic t_reset();
    rd(8'h00, v); check("R9 enable", v, 0);
    rd(8'h04, v); check("R9 raw", v, 0);
    rd(8'h18, v); check("R9 source", v, 0);
    for (int i = 0; i < 4; i++) begin
      rd(8'h44 + 8'(32 * i), v); check("R9 status", v, 32'h100);
    end
    check("R9 irq", 32'(irq), 0);
    rd(8'h60, v); check("R7 empty read after reset", v, 0);
    rd(8'h14, v); check("R7 underflow bit1", v, 32'h2);
    wr(8'h14, 32'h2);
    rd(8'h14, v); check("R7 underflow cleared", v, 0);
  endtask

  task automatic t_gate();
    wr(8'h18, 32'h5555);
    wr(8'h00, 32'h1);
    trig(); exp_q.push_back(next_sample());
    rd(8'h44, v); check("R1/R8 seq0 one entry", v, 32'h010);
    rd(8'h64, v); check("R1 seq1 disabled empty", v, 32'h100);
    wr(8'h00, 32'h0);
    trig();
    rd(8'h44, v); check("R1 all disabled no capture", v, 32'h010);
  endtask

  task automatic t_select();
    wr(8'h18, 32'h5535);
    wr(8'h00, 32'h2);
    trig();
    rd(8'h64, v); check("R2 code 3 ignored", v, 32'h100);
  endtask

  task automatic t_pop();
    rd(8'h40, v); check("R5 first sample", v, exp_q.pop_front());
    rd(8'h44, v); check("R8 seq0 drained", v, 32'h111);
  endtask

  task automatic t_multi();
    logic [31:0] e0, e2;
    wr(8'h18, 32'h5555);
    wr(8'h00, 32'h5);
    trig(); e0 = next_sample(); e2 = next_sample();
    rd(8'h40, v); check("R5 seq0 first draw", v, e0);
    rd(8'h80, v); check("R5 seq2 second draw", v, e2);
  endtask

  task automatic t_irq();
    wr(8'h08, 32'h1);
    @(negedge clk); check("R6 irq masked", 32'(irq), 32'h1);
    wr(8'h0C, 32'h1);
    @(negedge clk); check("R6 irq cleared", 32'(irq), 32'h0);
    rd(8'h04, v); check("R6 raw after clear", v, 32'h4);
    wr(8'h08, 32'h0);
  endtask

  task automatic t_overflow();
    wr(8'h00, 32'h8);
    for (int k = 0; k < 17; k++) begin
      trig(); v = next_sample();
      if (k < 16) exp_q.push_back(v);
    end
    rd(8'h10, v); check("R4 overflow bit3", v, 32'h8);
    rd(8'hA4, v); check("R8 seq3 full", v, 32'h200);
    wr(8'h00, 32'h0);
    for (int k = 0; k < 16; k++) begin
      lastv = exp_q.pop_front();
      rd(8'hA0, v); check("R3 FIFO order", v, lastv);
    end
    rd(8'hA0, v); check("R7 empty returns last", v, lastv);
    rd(8'h14, v); check("R7 underflow bit3", v, 32'h8);
    wr(8'h10, 32'h8);
    rd(8'h10, v); check("R4 overflow cleared", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_gate();
    t_select();
    t_pop();
    t_multi();
    t_irq();
    t_overflow();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule